// File: doc/BRIEF.md
# Fixed-Size Flit Assembler With CRC and FEC

This block turns a byte stream of transaction payload into fixed 256-byte flow-control units (flits). Each flit has four regions. The first is a payload area that holds 236 bytes. The second is a 6-byte link-control field, taken from a side input at the start of every flit. The third is a 64-bit CRC that covers everything before it. The last is 6 bytes of light forward error correction. Packets are packed straight into the payload area, with no framing tokens and no per-packet check codes. When the payload source has no data ready, zero bytes are inserted so that the flit keeps its cadence.

While flit generation is enabled, the assembler emits one byte per clock. Every byte comes with its index inside the flit and a start-of-flit strobe, so downstream lane logic can align to the flit. A flit that has started always runs to completion. If generation is still enabled on its last byte, the next flit follows with no idle cycle in between.

Top module: `flit_assembler`

## Requirements
- R1: A flit is exactly 256 output bytes on consecutive cycles, with `out_idx` counting 0 to 255. `out_sof` is high only with the byte whose index is 0.
- R2: Flit bytes 0..235 are the payload region. `pay_ready` is high in exactly those 236 byte cycles of each flit. A byte accepted there (`pay_valid` and `pay_ready`) appears at that index in accepted order, one cycle later on the output.
- R3: In a payload cycle where `pay_valid` is low, the byte at that index is 0x00. The timing of the flit does not change.
- R4: `ctrl_word` is sampled in the cycle of flit byte 0. Bits 47:40 go out at index 236, down to bits 7:0 at index 241. Changes to `ctrl_word` in any other cycle have no effect on that flit.
- R5: Bytes 242..249 hold a 64-bit CRC over bytes 0..241. The CRC is computed MSB-first per byte with polynomial `CRC_POLY` (default 0x42F0E1EBA9EA3693), starts from all ones and has no final inversion. It is sent most significant byte first.
- R6: Byte i of the range 0..249 belongs to FEC group i mod 3. Each group g yields two bytes: the XOR of its bytes, at index 250+2g, and a Horner sum over GF(2^8) (x^8+x^4+x^3+x^2+1), each step multiplying by 0x02 and adding the next byte in index order, at index 251+2g.
- R7: When `flit_en` is high in the cycle of byte 255, byte 0 of the next flit is produced in the following cycle. When it is low, output stops after byte 255. A flit that has started always completes, whatever `flit_en` does.
- R8: After reset, `out_valid`, `out_sof` and `pay_ready` are low until a flit starts.
- R9: Each flit's CRC, FEC and control field depend only on that flit's own bytes and on `ctrl_word` at its byte 0. A back-to-back flit carries nothing over from the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flit_en | input | 1 | Start or continue flit generation |
| pay_valid | input | 1 | Payload byte available |
| pay_data | input | 8 | Payload byte |
| pay_ready | output | 1 | Payload byte accepted this cycle if valid |
| ctrl_word | input | 48 | Link-control field, sampled at flit byte 0 |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First byte of a flit |
| out_idx | output | 8 | Index of the output byte within its flit |
| out_data | output | 8 | Output byte |

## Verification
Two things happen in the same clock when flits run back to back. The last FEC byte of one flit is emitted, and the next flit restarts: its CRC is reseeded, its FEC groups are cleared and its control field is captured. To provoke this, `flit_en` is held high across three flits, each with a different payload pattern and control word, and the last flit carries no payload at all. Every byte of each flit is compared with a model built from scratch for that flit alone. Any state left over from the previous flit, or a one-cycle gap, therefore shows up as a wrong byte or a wrong index.

// File: rtl/flit_pkg.sv
package flit_pkg;

  localparam int unsigned CRC_W = 64;

  typedef enum logic [1:0] {
    SEG_PAY  = 2'd0,
    SEG_CTRL = 2'd1,
    SEG_CRC  = 2'd2,
    SEG_FEC  = 2'd3
  } seg_e;

  // One byte through the CRC register, most significant data bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] state,
                                                input logic [7:0]       data,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = state;
    for (int k = 7; k >= 0; k--) begin
      fb = c[CRC_W-1] ^ data[k];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return c;
  endfunction

  // Multiply by the field generator 0x02 modulo x^8+x^4+x^3+x^2+1.
  function automatic logic [7:0] gf_times_alpha(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1D : 8'h00);
  endfunction

endpackage

// File: rtl/flit_seq.sv
module flit_seq
  import flit_pkg::*;
#(
  parameter int unsigned PAY_BYTES  = 236,
  parameter int unsigned CTRL_BYTES = 6,
  parameter int unsigned CRC_BYTES  = 8,
  parameter int unsigned FEC_BYTES  = 6,
  parameter int unsigned IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flit_en,
  output logic             run,
  output logic [IDX_W-1:0] idx,
  output logic             first,
  output logic             last,
  output seg_e             seg,
  output logic [IDX_W-1:0] seg_off
);

  localparam int unsigned FLIT_BYTES = PAY_BYTES + CTRL_BYTES + CRC_BYTES + FEC_BYTES;
  localparam logic [IDX_W-1:0] CTRL_BASE = IDX_W'(PAY_BYTES);
  localparam logic [IDX_W-1:0] CRC_BASE  = IDX_W'(PAY_BYTES + CTRL_BYTES);
  localparam logic [IDX_W-1:0] FEC_BASE  = IDX_W'(PAY_BYTES + CTRL_BYTES + CRC_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FLIT_BYTES - 1);

  logic             run_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else if (!run_q || idx_q == LAST_IDX) begin
      run_q <= flit_en;
      idx_q <= '0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign run   = run_q;
  assign idx   = idx_q;
  assign first = run_q && (idx_q == '0);
  assign last  = run_q && (idx_q == LAST_IDX);

  always_comb begin
    if (idx_q < CTRL_BASE) begin
      seg     = SEG_PAY;
      seg_off = idx_q;
    end else if (idx_q < CRC_BASE) begin
      seg     = SEG_CTRL;
      seg_off = idx_q - CTRL_BASE;
    end else if (idx_q < FEC_BASE) begin
      seg     = SEG_CRC;
      seg_off = idx_q - CRC_BASE;
    end else begin
      seg     = SEG_FEC;
      seg_off = idx_q - FEC_BASE;
    end
  end

endmodule

// File: rtl/flit_crc.sv
module flit_crc
  import flit_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 64'h42F0E1EBA9EA3693
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] base;

  assign base = restart ? '1 : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (step) crc_q <= crc_step(base, din, POLY);
  end

  assign crc = crc_q;

endmodule

// File: rtl/flit_fec.sv
module flit_fec
  import flit_pkg::*;
#(
  parameter int unsigned WAYS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_en,
  input  logic                    restart,
  input  logic [7:0]              din,
  output logic [2*WAYS-1:0][7:0]  par
);

  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] way_q;
  logic [WAY_W-1:0] way_cur;

  assign way_cur = restart ? '0 : way_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      way_q <= '0;
    else if (acc_en) way_q <= (way_cur == WAY_LAST) ? '0 : way_cur + 1'b1;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [7:0] sum_q;
    logic [7:0] hor_q;
    logic       hit;

    assign hit = acc_en && (way_cur == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q <= 8'h00;
        hor_q <= 8'h00;
      end else if (hit) begin
        sum_q <= (restart ? 8'h00 : sum_q) ^ din;
        hor_q <= gf_times_alpha(restart ? 8'h00 : hor_q) ^ din;
      end else if (acc_en && restart) begin
        sum_q <= 8'h00;
        hor_q <= 8'h00;
      end
    end

    assign par[2*w]   = sum_q;
    assign par[2*w+1] = hor_q;
  end

endmodule

// File: rtl/flit_assembler.sv
module flit_assembler
  import flit_pkg::*;
#(
  parameter logic [63:0] CRC_POLY   = 64'h42F0E1EBA9EA3693,
  parameter int unsigned PAY_BYTES  = 236,
  parameter int unsigned CTRL_BYTES = 6,
  parameter int unsigned FEC_WAYS   = 3,
  localparam int unsigned CRC_BYTES  = CRC_W / 8,
  localparam int unsigned FEC_BYTES  = 2 * FEC_WAYS,
  localparam int unsigned FLIT_BYTES = PAY_BYTES + CTRL_BYTES + CRC_BYTES + FEC_BYTES,
  localparam int unsigned IDX_W      = $clog2(FLIT_BYTES),
  localparam int unsigned CTRL_W     = 8 * CTRL_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flit_en,
  input  logic              pay_valid,
  input  logic [7:0]        pay_data,
  output logic              pay_ready,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              out_valid,
  output logic              out_sof,
  output logic [IDX_W-1:0]  out_idx,
  output logic [7:0]        out_data
);

  // Internal events, named for the checker
  logic             flit_run;
  logic             flit_first;
  logic             flit_last;
  logic             pay_take;
  logic             code_step;
  seg_e             seg;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] seg_off;

  logic [CTRL_W-1:0]          ctrl_q;
  logic [CRC_W-1:0]           crc_val;
  logic [FEC_BYTES-1:0][7:0]  fec_par;
  logic [7:0]                 cur_byte;

  flit_seq #(
    .PAY_BYTES (PAY_BYTES),
    .CTRL_BYTES(CTRL_BYTES),
    .CRC_BYTES (CRC_BYTES),
    .FEC_BYTES (FEC_BYTES),
    .IDX_W     (IDX_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flit_en(flit_en),
    .run    (flit_run),
    .idx    (idx),
    .first  (flit_first),
    .last   (flit_last),
    .seg    (seg),
    .seg_off(seg_off)
  );

  assign pay_ready = flit_run && (seg == SEG_PAY);
  assign pay_take  = pay_ready && pay_valid;
  assign code_step = flit_run && (seg == SEG_PAY || seg == SEG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctrl_q <= '0;
    else if (flit_first) ctrl_q <= ctrl_word;
  end

  flit_crc #(
    .POLY(CRC_POLY)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (code_step),
    .restart(flit_first),
    .din    (cur_byte),
    .crc    (crc_val)
  );

  flit_fec #(
    .WAYS(FEC_WAYS)
  ) u_fec (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_en (flit_run && (seg != SEG_FEC)),
    .restart(flit_first),
    .din    (cur_byte),
    .par    (fec_par)
  );

  // Byte selection for the current flit position
  always_comb begin
    logic [CTRL_W-1:0] ctrl_sh;
    logic [CRC_W-1:0]  crc_sh;
    int                sel_i;
    cur_byte = 8'h00;
    ctrl_sh  = '0;
    crc_sh   = '0;
    sel_i    = int'(seg_off);
    case (seg)
      SEG_PAY:  cur_byte = pay_take ? pay_data : 8'h00;
      SEG_CTRL: begin
        ctrl_sh  = ctrl_q >> (8 * (int'(CTRL_BYTES) - 1 - sel_i));
        cur_byte = ctrl_sh[7:0];
      end
      SEG_CRC: begin
        crc_sh   = crc_val >> (8 * (int'(CRC_BYTES) - 1 - sel_i));
        cur_byte = crc_sh[7:0];
      end
      SEG_FEC: begin
        for (int f = 0; f < int'(FEC_BYTES); f++) begin
          if (sel_i == f) cur_byte = fec_par[f];
        end
      end
      default: cur_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_idx   <= '0;
      out_data  <= 8'h00;
    end else begin
      out_valid <= flit_run;
      out_sof   <= flit_first;
      out_idx   <= idx;
      out_data  <= cur_byte;
    end
  end

endmodule

// File: rtl/flit_assembler_chk.sv
module flit_assembler_chk #(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned FLIT_BYTES = 256,
  parameter int unsigned PAY_BYTES  = 236
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flit_en,
  input logic             pay_valid,
  input logic             pay_ready,
  input logic             flit_first,
  input logic             flit_last,
  input logic             out_valid,
  input logic             out_sof,
  input logic [IDX_W-1:0] out_idx,
  input logic [7:0]       out_data
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FLIT_BYTES - 1);
  localparam logic [IDX_W-1:0] PAY_LIM  = IDX_W'(PAY_BYTES);

  // R1
  sof_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_valid && out_idx == '0));

  // R1
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx != LAST_IDX) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

  // R2
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |=> (out_valid && out_idx < PAY_LIM));

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx < PAY_LIM && !$past(pay_valid)) |-> (out_data == 8'h00));

  // R7
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_last && flit_en) |=> flit_first);

  // R8
  sof_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof);

endmodule

bind flit_assembler flit_assembler_chk #(
  .IDX_W     (IDX_W),
  .FLIT_BYTES(FLIT_BYTES),
  .PAY_BYTES (PAY_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flit_en   (flit_en),
  .pay_valid (pay_valid),
  .pay_ready (pay_ready),
  .flit_first(flit_first),
  .flit_last (flit_last),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_idx   (out_idx),
  .out_data  (out_data)
);

// File: tb/flit_assembler_test.sv
`timescale 1ns/1ps
module flit_assembler_test;

  localparam logic [63:0] POLY = 64'h42F0E1EBA9EA3693;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flit_en = 1'b0;
  logic        pay_valid = 1'b0;
  logic [7:0]  pay_data = 8'h00;
  logic        pay_ready;
  logic [47:0] ctrl_word = 48'h0;
  logic        out_valid;
  logic        out_sof;
  logic [7:0]  out_idx;
  logic [7:0]  out_data;

  always #2 clk = ~clk;

  flit_assembler uut (
    .clk(clk), .rst_n(rst_n), .flit_en(flit_en),
    .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
    .ctrl_word(ctrl_word),
    .out_valid(out_valid), .out_sof(out_sof), .out_idx(out_idx), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] obuf [0:1023];
  logic [7:0] oidx [0:1023];
  logic       osof [0:1023];
  logic [7:0] exp_pay [0:2][0:235];
  logic [7:0] exp_flit [0:255];
  int ocount = 0;
  int rdy_cnt = 0;
  bit cap_on = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cap_on) begin
      if (out_valid && ocount < 1024) begin
        obuf[ocount] = out_data;
        oidx[ocount] = out_idx;
        osof[ocount] = out_sof;
        ocount++;
      end
      if (pay_ready) rdy_cnt++;
    end
  end

  // ---- reference model -------------------------------------------------
  function automatic logic [7:0] bm_gfmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    logic [7:0] y = b;
    for (int k = 0; k < 8; k++) begin
      if (y[0]) r ^= x;
      y = y >> 1;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] bm_apow(input int e);
    logic [7:0] p = 8'h01;
    for (int k = 0; k < e; k++) p = bm_gfmul(p, 8'h02);
    return p;
  endfunction

  function automatic logic [47:0] ctrl_of(input int pat, input int f);
    return 48'h5A3C_0F1E_9D27 ^ {8'(pat), 8'(f), 32'h1357_9BDF} ^ (48'(f) << 40);
  endfunction

  function automatic bit pat_valid(input int pat, input int f, input int k);
    case (pat)
      0: return 1'b1;
      1: return (k % 3 != 1) && (k < 150);
      default: return (f == 0) ? 1'b1 : (f == 1) ? (k % 2 == 0) : 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] pat_data(input int pat, input int f, input int k);
    case (pat)
      0: return 8'(k * 7 + f * 31 + 1);
      1: return 8'(k) ^ 8'hA5;
      default: return (f == 0) ? 8'(k) : 8'(255 - k);
    endcase
  endfunction

  task automatic build_model(input int pat, input int f);
    logic [63:0] c;
    logic [47:0] cw;
    logic [7:0]  p0, p1;
    int n, j;
    for (int i = 0; i < 236; i++) exp_flit[i] = exp_pay[f][i];
    cw = ctrl_of(pat, f);
    for (int i = 0; i < 6; i++) exp_flit[236 + i] = cw[47 - 8*i -: 8];
    c = '1;
    for (int i = 0; i < 242; i++) begin
      c ^= {exp_flit[i], 56'h0};
      for (int b = 0; b < 8; b++) c = c[63] ? ((c << 1) ^ POLY) : (c << 1);
    end
    for (int i = 0; i < 8; i++) exp_flit[242 + i] = c[63 - 8*i -: 8];
    for (int w = 0; w < 3; w++) begin
      n = 0;
      for (int i = w; i < 250; i += 3) n++;
      p0 = 8'h00; p1 = 8'h00; j = 0;
      for (int i = w; i < 250; i += 3) begin
        p0 ^= exp_flit[i];
        p1 ^= bm_gfmul(exp_flit[i], bm_apow(n - 1 - j));
        j++;
      end
      exp_flit[250 + 2*w] = p0;
      exp_flit[251 + 2*w] = p1;
    end
  endtask

  // ---- stimulus and comparison -----------------------------------------
  task automatic run_flits(input int nflits, input int pat);
    int slot = 0;
    int f, k;
    bit v;
    logic [7:0] d;
    string req;
    ocount = 0; rdy_cnt = 0; cap_on = 1;
    @(negedge clk);
    flit_en = 1'b1;
    ctrl_word = ctrl_of(pat, 0);
    pay_valid = 1'b0;
    for (int cyc = 0; cyc < nflits*256 + 4; cyc++) begin
      @(negedge clk);
      ctrl_word = ctrl_of(pat, slot / 236);
      flit_en = (cyc < (nflits - 1)*256 + 100);
      if (pay_ready) begin
        f = slot / 236; k = slot % 236;
        v = pat_valid(pat, f, k);
        d = pat_data(pat, f, k);
        pay_valid = v;
        pay_data  = v ? d : 8'h3C;
        exp_pay[f][k] = v ? d : 8'h00;
        slot++;
      end else begin
        pay_valid = 1'b1;
        pay_data  = 8'hEE;
      end
    end
    pay_valid = 1'b0;
    cap_on = 0;
    // R7: run stops after the last flit, R1: length
    check(ocount == nflits*256, "R1", "byte count", 64'(ocount), 64'(nflits*256));
    check(rdy_cnt == nflits*236, "R2", "ready cycles", 64'(rdy_cnt), 64'(nflits*236));
    check(out_valid == 1'b0 && pay_ready == 1'b0, "R7", "idle after last flit",
          {out_valid, pay_ready}, 64'h0);
    for (int fl = 0; fl < nflits; fl++) begin
      build_model(pat, fl);
      for (int i = 0; i < 256; i++) begin
        int o = fl*256 + i;
        if (o < ocount) begin
          check(oidx[o] == 8'(i) && osof[o] == (i == 0), "R1", "index/sof",
                {osof[o], oidx[o]}, {(i == 0), 8'(i)});
          if (i < 236)      req = (pat_valid(pat, fl, i)) ? "R2" : "R3";
          else if (i < 242) req = "R4";
          else if (i < 250) req = "R5";
          else              req = "R6";
          if (fl > 0) req = {req, " R9"};
          check(obuf[o] == exp_flit[i], req, $sformatf("flit %0d byte %0d", fl, i),
                64'(obuf[o]), 64'(exp_flit[i]));
        end
      end
    end
  endtask

  task automatic test_reset;
    check(out_valid == 1'b0 && out_sof == 1'b0, "R8", "outputs idle in reset",
          {out_valid, out_sof}, 64'h0);
    check(pay_ready == 1'b0, "R8", "ready low in reset", 64'(pay_ready), 64'h0);
  endtask

  task automatic test_idle_after_reset;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0 && pay_ready == 1'b0, "R8", "idle with flit_en low",
          {out_valid, pay_ready}, 64'h0);
  endtask

  task automatic test_full_flit;      // R2 R4 R5 R6
    run_flits(1, 0);
  endtask

  task automatic test_padding;        // R3 R4 ignore of later ctrl changes
    run_flits(1, 1);
  endtask

  task automatic test_back_to_back;   // R7 R9
    run_flits(3, 2);
    repeat (6) @(negedge clk);
    check(out_valid == 1'b0, "R7", "stays idle", 64'(out_valid), 64'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_idle_after_reset();
    test_full_flit();
    test_padding();
    test_back_to_back();
    finish_run();
  end

endmodule